// File: doc/BRIEF.md
# Bidirectional Full-Bridge Gate Pattern Generator

This block turns one PWM switching bit into the four gate commands of a single-phase full bridge that can move power either way between the grid and a DC bus. It picks one of four switching patterns from two inputs. The first is the polarity of the grid voltage. The second is the power direction, which is the sign of a signed voltage-amplitude command from the bus regulator; no current measurement is needed.

When power flows from the grid, a single switch of leg A modulates and the other three stay off. When power flows back to the grid, one switch of leg A conducts for the whole half-cycle. The opposite-rail switch of leg B then modulates with the inverted switching bit.

The polarity and direction are sampled only on a carrier-period strobe, so a zero crossing cannot change the pattern in the middle of a period. The gate requests pass through a register stage. A per-leg dead-time stage then delays every rising gate edge by a parameterised number of clocks. A disable input clears all four gates at the next clock edge.

Top module: `bridge_gate_gen`

## Requirements
- R1: The direction is rectifying when the signed command `ampCmd` is greater than or equal to zero, and inverting when it is negative; a command of exactly zero selects rectifying.
- R2: Rectifying with `gridSignIn`=1: `gateALo` follows `pwmIn` and the other three gates stay low.
- R3: Rectifying with `gridSignIn`=0: `gateAHi` follows `pwmIn` and the other three gates stay low.
- R4: Inverting with `gridSignIn`=1: `gateAHi` is held high, `gateBLo` follows the complement of `pwmIn`, and `gateALo` and `gateBHi` stay low.
- R5: Inverting with `gridSignIn`=0: `gateALo` is held high, `gateBHi` follows the complement of `pwmIn`, and `gateAHi` and `gateBLo` stay low.
- R6: `ampCmd` and `gridSignIn` are captured only at a clock edge where `periodStart` is 1. A change at any other time has no effect on the gates.
- R7: The high-side and low-side gates of the same leg are never high in the same cycle.
- R8: A gate falls at the second clock edge after its request is removed at the inputs. It rises at edge 2+`DEAD_CYC` after its request appears, provided the request is held throughout.
- R9: When `gateDisable` is sampled high at a clock edge, all four gates are low after that edge and stay low while it is held.
- R10: Reset drives all gates low and selects the rectifying, positive-polarity pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwmIn | input | 1 | Switching bit from the carrier comparator |
| gridSignIn | input | 1 | Grid voltage polarity, 1 when the voltage is zero or positive |
| ampCmd | input | CMD_W | Signed voltage-amplitude command; its sign sets the power direction |
| periodStart | input | 1 | One-cycle strobe at the start of each carrier period |
| gateDisable | input | 1 | Forces all gates low |
| gateAHi | output | 1 | Leg A high-side gate |
| gateALo | output | 1 | Leg A low-side gate |
| gateBHi | output | 1 | Leg B high-side gate |
| gateBLo | output | 1 | Leg B low-side gate |

## Verification
The pattern properties assume the captured mode has been stable for at least three clock samples. Only then has the two-stage gate path caught up after a mode change. The stimulus therefore holds each mode for several dead-time windows before it changes `periodStart` inputs again. The properties also assume `gateDisable` is a level held for whole cycles. The bench asserts it only at falling clock edges, so the value seen at each rising edge is well defined. `pwmIn` may toggle in any cycle. The bench drives both its levels in every mode, plus single steps timed edge by edge, to measure the rise and fall latency.

// File: rtl/bgp_pkg.sv
package bgp_pkg;

  typedef struct packed {
    logic loadMode;
    logic blank;
  } bgp_strobe_t;

  typedef struct packed {
    logic rectify;
    logic posHalf;
  } bgp_mode_t;

  localparam bgp_mode_t MODE_AT_RESET = '{rectify: 1'b1, posHalf: 1'b1};

  localparam int GATE_N = 4;

endpackage

// File: rtl/bgp_leg.sv
module bgp_leg #(
  parameter int DEAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic [1:0] reqIn,
  output logic [1:0] gateOut
);

  localparam int CNT_W = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEAD_CYC);

  logic [1:0] safeReq;

  // a leg never receives both requests; treat that as neither
  always_comb safeReq = (&reqIn) ? 2'b00 : reqIn;

  for (genvar s = 0; s < 2; s++) begin : g_side
    if (DEAD_CYC == 0) begin : g_direct
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      gateOut[s] <= 1'b0;
        else if (clear) gateOut[s] <= 1'b0;
        else            gateOut[s] <= safeReq[s];
      end
    end else begin : g_delay
      logic [CNT_W-1:0] holdCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdCnt    <= '0;
          gateOut[s] <= 1'b0;
        end else if (clear || !safeReq[s]) begin
          holdCnt    <= '0;
          gateOut[s] <= 1'b0;
        end else begin
          holdCnt    <= (holdCnt == CNT_TOP) ? holdCnt : holdCnt + 1'b1;
          gateOut[s] <= (holdCnt == CNT_TOP);
        end
      end
    end
  end

endmodule

// File: rtl/bgp_ctrl.sv
module bgp_ctrl
  import bgp_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic [CMD_W-1:0] ampCmd,
  input  logic             gridSignIn,
  input  logic             periodStart,
  input  logic             gateDisable,
  output bgp_strobe_t      strobe,
  output bgp_mode_t        nextMode
);

  always_comb begin
    nextMode.rectify = ($signed(ampCmd) >= 0);
    nextMode.posHalf = gridSignIn;
    strobe.loadMode  = periodStart;
    strobe.blank     = gateDisable;
  end

endmodule

// File: rtl/bgp_datapath.sv
module bgp_datapath
  import bgp_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bgp_strobe_t       strobe,
  input  bgp_mode_t         nextMode,
  input  logic              pwmIn,
  output bgp_mode_t         curMode,
  output logic [GATE_N-1:0] gates
);

  localparam int LEG_N = GATE_N / 2;

  // bit order {A high, A low, B high, B low}
  logic [GATE_N-1:0] rawReq;
  logic [GATE_N-1:0] reqReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curMode <= MODE_AT_RESET;
    else if (strobe.loadMode) curMode <= nextMode;
  end

  always_comb begin
    unique case ({curMode.rectify, curMode.posHalf})
      2'b11:   rawReq = {1'b0, pwmIn, 1'b0, 1'b0};
      2'b10:   rawReq = {pwmIn, 1'b0, 1'b0, 1'b0};
      2'b01:   rawReq = {1'b1, 1'b0, 1'b0, ~pwmIn};
      default: rawReq = {1'b0, 1'b1, ~pwmIn, 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            reqReg <= '0;
    else if (strobe.blank) reqReg <= '0;
    else                  reqReg <= rawReq;
  end

  for (genvar g = 0; g < LEG_N; g++) begin : g_leg
    bgp_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strobe.blank),
      .reqIn  (reqReg[GATE_N-1-2*g -: 2]),
      .gateOut(gates[GATE_N-1-2*g -: 2])
    );
  end

endmodule

// File: rtl/bridge_gate_gen.sv
module bridge_gate_gen
  import bgp_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int DEAD_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwmIn,
  input  logic             gridSignIn,
  input  logic [CMD_W-1:0] ampCmd,
  input  logic             periodStart,
  input  logic             gateDisable,
  output logic             gateAHi,
  output logic             gateALo,
  output logic             gateBHi,
  output logic             gateBLo
);

  bgp_strobe_t       strobe;
  bgp_mode_t         nextMode;
  bgp_mode_t         curMode;
  logic [GATE_N-1:0] gates;
  logic              modeRectify;
  logic              modePosHalf;

  bgp_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .ampCmd     (ampCmd),
    .gridSignIn (gridSignIn),
    .periodStart(periodStart),
    .gateDisable(gateDisable),
    .strobe     (strobe),
    .nextMode   (nextMode)
  );

  bgp_datapath #(.DEAD_CYC(DEAD_CYC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .nextMode(nextMode),
    .pwmIn   (pwmIn),
    .curMode (curMode),
    .gates   (gates)
  );

  assign {gateAHi, gateALo, gateBHi, gateBLo} = gates;
  assign modeRectify = curMode.rectify;
  assign modePosHalf = curMode.posHalf;

endmodule

// File: rtl/bgp_checker.sv
module bgp_checker (
  input logic clk,
  input logic rstN,
  input logic periodStart,
  input logic gateDisable,
  input logic modeRectify,
  input logic modePosHalf,
  input logic gateAHi,
  input logic gateALo,
  input logic gateBHi,
  input logic gateBLo
);

  logic invPos;
  logic invNeg;
  assign invPos = !modeRectify && modePosHalf;
  assign invNeg = !modeRectify && !modePosHalf;

  // R7
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateAHi && gateALo));

  // R7
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateBHi && gateBLo));

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateDisable |=> !(gateAHi || gateALo || gateBHi || gateBLo));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |=> ($stable(modeRectify) && $stable(modePosHalf)));

  // R2 R3
  rect_b_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRectify && $past(modeRectify) && $past(modeRectify, 2))
      |-> (!gateBHi && !gateBLo));

  // R4
  inv_pos_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invPos && $past(invPos) && $past(invPos, 2)) |-> (!gateALo && !gateBHi));

  // R5
  inv_neg_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invNeg && $past(invNeg) && $past(invNeg, 2)) |-> (!gateAHi && !gateBLo));

endmodule

bind bridge_gate_gen bgp_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .periodStart(periodStart),
  .gateDisable(gateDisable),
  .modeRectify(modeRectify),
  .modePosHalf(modePosHalf),
  .gateAHi    (gateAHi),
  .gateALo    (gateALo),
  .gateBHi    (gateBHi),
  .gateBLo    (gateBLo)
);

// File: tb/bridge_gate_gen_tb.sv
module bridge_gate_gen_tb;

  localparam int CMD_W  = 16;
  localparam int DEAD   = 2;
  localparam int SETTLE = DEAD + 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pwmIn = 1'b0;
  logic             gridSignIn = 1'b1;
  logic [CMD_W-1:0] ampCmd = '0;
  logic             periodStart = 1'b0;
  logic             gateDisable = 1'b0;
  logic             gateAHi, gateALo, gateBHi, gateBLo;

  int checks = 0;
  int fails = 0;
  int exclHits = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bridge_gate_gen #(.CMD_W(CMD_W), .DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .gridSignIn(gridSignIn),
    .ampCmd(ampCmd), .periodStart(periodStart), .gateDisable(gateDisable),
    .gateAHi(gateAHi), .gateALo(gateALo), .gateBHi(gateBHi), .gateBLo(gateBLo)
  );

  // R7 monitor across the whole run
  always @(negedge clk)
    if (rstN && ((gateAHi && gateALo) || (gateBHi && gateBLo))) exclHits++;

  function automatic logic [3:0] pat();
    return {gateAHi, gateALo, gateBHi, gateBLo};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: gates got %b expected %b", req, got, exp);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic loadMode(input logic signed [CMD_W-1:0] cmd, input logic pol);
    ampCmd = cmd;
    gridSignIn = pol;
    periodStart = 1'b1;
    tick(1);
    periodStart = 1'b0;
    tick(SETTLE);
  endtask

  task automatic expectPat(input logic pwm, input logic [3:0] exp, input string req);
    pwmIn = pwm;
    tick(SETTLE);
    check(req, pat(), exp);
  endtask

  task automatic testReset();
    check("R10 reset", pat(), 4'b0000);
    rstN = 1'b1;
    pwmIn = 1'b1;
    tick(SETTLE);
    check("R10 reset mode", pat(), 4'b0100);
  endtask

  task automatic testRectPos();
    loadMode(16'sd100, 1'b1);
    expectPat(1'b0, 4'b0000, "R2 pwm0");
    expectPat(1'b1, 4'b0100, "R2 pwm1");
  endtask

  task automatic testRectNeg();
    loadMode(16'sd3000, 1'b0);
    expectPat(1'b1, 4'b1000, "R3 pwm1");
    expectPat(1'b0, 4'b0000, "R3 pwm0");
  endtask

  task automatic testZeroCmd();
    loadMode(16'sd0, 1'b1);
    expectPat(1'b1, 4'b0100, "R1 zero cmd");
  endtask

  task automatic testInvPos();
    loadMode(-16'sd5, 1'b1);
    expectPat(1'b0, 4'b1001, "R4 pwm0");
    expectPat(1'b1, 4'b1000, "R4 pwm1");
    check("R1 negative cmd", pat(), 4'b1000);
  endtask

  task automatic testInvNeg();
    loadMode(-16'sd32768, 1'b0);
    expectPat(1'b0, 4'b0110, "R5 pwm0");
    expectPat(1'b1, 4'b0100, "R5 pwm1");
  endtask

  task automatic testHold();
    pwmIn = 1'b0;
    tick(SETTLE);
    ampCmd = 16'd50;
    gridSignIn = 1'b1;
    tick(SETTLE);
    check("R6 no strobe", pat(), 4'b0110);
    periodStart = 1'b1;
    tick(1);
    periodStart = 1'b0;
    tick(SETTLE);
    check("R6 strobe", pat(), 4'b0000);
  endtask

  task automatic testDeadTime();
    loadMode(16'sd10, 1'b1);
    pwmIn = 1'b0;
    tick(SETTLE);
    pwmIn = 1'b1;
    for (int i = 1; i <= DEAD + 2; i++) begin
      tick(1);
      check("R8 rise", pat(), (i >= DEAD + 2) ? 4'b0100 : 4'b0000);
    end
    pwmIn = 1'b0;
    tick(1);
    check("R8 fall edge1", pat(), 4'b0100);
    tick(1);
    check("R8 fall edge2", pat(), 4'b0000);
  endtask

  task automatic testDisable();
    loadMode(-16'sd7, 1'b1);
    pwmIn = 1'b0;
    tick(SETTLE);
    check("R9 before", pat(), 4'b1001);
    gateDisable = 1'b1;
    tick(1);
    check("R9 one edge", pat(), 4'b0000);
    tick(4);
    check("R9 held", pat(), 4'b0000);
    gateDisable = 1'b0;
    tick(SETTLE);
    check("R9 release", pat(), 4'b1001);
  endtask

  initial begin
    tick(3);
    testReset();
    testRectPos();
    testRectNeg();
    testZeroCmd();
    testInvPos();
    testInvNeg();
    testHold();
    testInvNeg();
    testInvPos();
    testDeadTime();
    testDisable();
    checks++;
    if (exclHits != 0) begin
      fails++;
      $display("FAIL R7: overlap cycles got %0d expected 0", exclHits);
    end
    finishUp();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishUp();
  end

endmodule